// File: doc/BRIEF.md
# FIS Receive DMA Engine

This block sits between the receive side of a SATA link layer and a memory system that accepts AXI4 write bursts. Frames arrive as a stream of 32-bit words with a last-word marker. The block classifies each frame from the low byte of its first word. Data frames lose that header word, and their payload goes to a data buffer region. Every other frame is kept whole, header included, and goes to a separate region for control frames.

Words are packed eight at a time into 256-bit beats and collected in a beat FIFO. A write engine waits until a full 16-beat burst is buffered. It then issues the address, streams the burst without gaps and waits for the write response. Each frame is padded with zero words up to a whole number of bursts, so every frame starts on a burst boundary of its region. Once the last word of a frame has been taken, the total word count and the frame class are shown on the status outputs. A one-cycle completion pulse follows when the frame's final burst has been acknowledged.

Software sets the two region base addresses. Both must be aligned to the 512-byte burst size. The processor uses the completion pulse and the status outputs to decide how to handle the frame it has just received.

Top module: `fisrx_dma`

## Requirements
- R1: A frame is a data frame when bits 7:0 of its first word equal 0x46. Every other value marks a control frame, and bits 31:8 of the first word play no part in the decision.
- R2: For a data frame the first word is not written. The remaining words are packed eight per 256-bit beat, with the earliest word in bits 31:0 and each later word in the next 32 bits up.
- R3: For a control frame every word is written, including the first, packed the same way as in R2.
- R4: A frame's first burst goes to `data_base_i` for a data frame and to `other_base_i` for a control frame. Each further burst of the same frame is 512 bytes above the one before it.
- R5: Each frame is padded with zero words up to a multiple of 128 words (16 beats). A frame with no stored words writes one all-zero burst. A frame that already fills whole bursts gets no extra burst.
- R6: Every burst has AWLEN = 15, AWSIZE = 5 and AWBURST = 01 (incrementing). WSTRB is all ones, and WLAST is high on the 16th beat only.
- R7: The address is issued only when a whole burst is buffered. AWVALID and AWADDR hold until accepted. W beats are offered only after the address handshake, and then without gaps until WLAST is accepted.
- R8: From the cycle after a frame's last word is accepted, `pkt_words_o` shows that frame's total word count (header included) and `pkt_non_data_o` is 1 for a control frame and 0 for a data frame. Both hold until the next frame ends.
- R9: `pkt_done_o` is a one-cycle pulse, raised in the cycle after the write response of a frame's final burst. There is exactly one pulse per frame.
- R10: `rx_ready_o` goes low while the beat FIFO is full or padding is being written. No word is lost or duplicated under such back-pressure.
- R11: While reset is held and right after it, `rx_ready_o` = 1, AWVALID = WVALID = BREADY = 0, `pkt_done_o` = 0, and the status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data_i | input | 32 | Received frame word |
| rx_valid_i | input | 1 | Word valid |
| rx_last_i | input | 1 | Word is the last of its frame |
| rx_ready_o | output | 1 | Block accepts a word this cycle |
| data_base_i | input | ADDR_W | Start address for data-frame payload |
| other_base_i | input | ADDR_W | Start address for control frames |
| m_awaddr | output | ADDR_W | Burst address |
| m_awlen | output | 8 | Burst length minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address accepted |
| m_wdata | output | 256 | Beat data |
| m_wstrb | output | 32 | Byte strobes |
| m_wlast | output | 1 | Final beat of burst |
| m_wvalid | output | 1 | Beat valid |
| m_wready | input | 1 | Beat accepted |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response accepted |
| pkt_words_o | output | 24 | Word count of the last completed frame |
| pkt_non_data_o | output | 1 | Last completed frame was a control frame |
| pkt_done_o | output | 1 | Final burst of a frame acknowledged |

## Verification
A wrong class latched at the first word shows up at the first AW handshake of that frame, as an address in the wrong region. A wrong lane or beat index corrupts the very beat it touches and is caught when the burst data is compared. It also moves WLAST off the 16th beat, or makes the padding end early so that a burst never completes and no completion pulse arrives. A lost last-burst marker shows up only as a missing or doubled `pkt_done_o`, one cycle after the final write response. The bench therefore counts pulses over a quiet window after each frame.

// File: rtl/fisrx_pkg.sv
package fisrx_pkg;

    localparam int WORD_W        = 32;
    localparam int LANES         = 8;
    localparam int BEAT_W        = WORD_W * LANES;
    localparam int BURST_BEATS   = 16;
    localparam int BURST_BYTES   = BURST_BEATS * BEAT_W / 8;
    localparam int CNT_W         = 24;
    localparam logic [7:0] DATA_FIS_CODE = 8'h46;

    localparam logic [7:0] AXI_LEN   = 8'(BURST_BEATS - 1);
    localparam logic [2:0] AXI_SIZE  = 3'($clog2(BEAT_W / 8));
    localparam logic [1:0] AXI_INCR  = 2'b01;

    // Side information carried with every buffered beat.
    typedef struct packed {
        logic first;    // first beat of a frame
        logic last;     // last (padded) beat of a frame
        logic to_data;  // frame goes to the data region
    } beat_tag_t;

    typedef enum logic [1:0] {
        IG_IDLE,
        IG_BODY,
        IG_PAD
    } ingest_state_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_ADDR,
        WR_DATA,
        WR_RESP
    } writer_state_e;

    function automatic logic is_data_fis(input logic [WORD_W-1:0] w);
        return w[7:0] == DATA_FIS_CODE;
    endfunction

endpackage

// File: rtl/fisrx_ingest.sv
module fisrx_ingest
    import fisrx_pkg::*;
#(
    parameter int W_W   = WORD_W,
    parameter int N_L   = LANES,
    parameter int N_B   = BURST_BEATS,
    parameter int C_W   = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W_W-1:0]       rx_data,
    input  logic                 rx_valid,
    input  logic                 rx_last,
    output logic                 rx_ready,
    input  logic                 fifo_full,
    output logic                 push,
    output logic [W_W*N_L-1:0]   push_data,
    output beat_tag_t            push_tag,
    output logic [C_W-1:0]       word_count,
    output logic                 non_data
);

    localparam int LANE_W = (N_L > 1) ? $clog2(N_L) : 1;
    localparam int BIDX_W = (N_B > 1) ? $clog2(N_B) : 1;
    localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(N_L - 1);
    localparam logic [BIDX_W-1:0] BEAT_TOP = BIDX_W'(N_B - 1);

    ingest_state_e           state_q, state_n;
    logic [LANE_W-1:0]       lane_q;
    logic [BIDX_W-1:0]       beat_q;
    logic [N_L-1:0][W_W-1:0] buf_q, buf_n;
    logic                    first_pend_q;
    logic                    to_data_q;
    logic [C_W-1:0]          cnt_q;

    logic accept, sop, hdr_data, pkt_data, store;
    logic lane_full, pad_push, eop, aligned_end;

    always_comb begin
        rx_ready  = (state_q != IG_PAD) && !fifo_full;
        accept    = rx_valid && rx_ready;
        sop       = (state_q == IG_IDLE);
        hdr_data  = is_data_fis(rx_data);
        pkt_data  = sop ? hdr_data : to_data_q;
        store     = accept && !(sop && hdr_data);
        lane_full = store && (lane_q == LANE_TOP);
        pad_push  = (state_q == IG_PAD) && !fifo_full;
        push      = lane_full || pad_push;
        eop       = accept && rx_last;
        // The frame ends exactly on a burst boundary with this word.
        aligned_end = eop && lane_full && (beat_q == BEAT_TOP);

        buf_n = buf_q;
        if (store) begin
            buf_n[lane_q] = rx_data;
        end

        for (int l = 0; l < N_L; l++) begin
            if (pad_push) begin
                push_data[l*W_W +: W_W] = (l < int'(lane_q)) ? buf_q[l] : '0;
            end else begin
                push_data[l*W_W +: W_W] = buf_n[l];
            end
        end

        push_tag.first   = first_pend_q;
        push_tag.to_data = pkt_data;
        push_tag.last    = (beat_q == BEAT_TOP) && (pad_push || aligned_end);

        state_n = state_q;
        case (state_q)
            IG_IDLE, IG_BODY: begin
                if (eop) begin
                    state_n = aligned_end ? IG_IDLE : IG_PAD;
                end else if (accept) begin
                    state_n = IG_BODY;
                end
            end
            IG_PAD: begin
                if (pad_push && (beat_q == BEAT_TOP)) begin
                    state_n = IG_IDLE;
                end
            end
            default: state_n = IG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= IG_IDLE;
            lane_q       <= '0;
            beat_q       <= '0;
            buf_q        <= '0;
            first_pend_q <= 1'b0;
            to_data_q    <= 1'b0;
            cnt_q        <= '0;
            word_count   <= '0;
            non_data     <= 1'b0;
        end else begin
            state_q <= state_n;
            if (store) begin
                buf_q <= buf_n;
            end
            if (push) begin
                lane_q       <= '0;
                beat_q       <= (beat_q == BEAT_TOP) ? '0 : beat_q + 1'b1;
                first_pend_q <= 1'b0;
            end else if (store) begin
                lane_q <= lane_q + 1'b1;
            end
            if (accept) begin
                if (sop) begin
                    to_data_q    <= hdr_data;
                    first_pend_q <= 1'b1;
                    cnt_q        <= C_W'(1);
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (eop) begin
                word_count <= sop ? C_W'(1) : cnt_q + 1'b1;
                non_data   <= !pkt_data;
            end
        end
    end

endmodule

// File: rtl/fisrx_beat_fifo.sv
module fisrx_beat_fifo #(
    parameter int WIDTH = 259,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head,
    output logic [$clog2(DEPTH):0]       count,
    output logic                         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic             do_push, do_pop;

    assign full    = (count == ($clog2(DEPTH) + 1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == PTR_TOP) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == PTR_TOP) ? '0 : rd_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/fisrx_axi_writer.sv
module fisrx_axi_writer
    import fisrx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = BEAT_W,
    parameter int CNT_W_F = 6,
    parameter int N_B    = BURST_BEATS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  data_base,
    input  logic [ADDR_W-1:0]  other_base,
    input  logic [CNT_W_F-1:0] fifo_count,
    input  logic [DATA_W-1:0]  head_data,
    input  beat_tag_t          head_tag,
    output logic               pop,
    output logic [ADDR_W-1:0]  awaddr,
    output logic               awvalid,
    input  logic               awready,
    output logic [DATA_W-1:0]  wdata,
    output logic               wlast,
    output logic               wvalid,
    input  logic               wready,
    input  logic               bvalid,
    output logic               bready,
    output logic               done
);

    localparam int BIDX_W = (N_B > 1) ? $clog2(N_B) : 1;
    localparam logic [BIDX_W-1:0] BEAT_TOP = BIDX_W'(N_B - 1);

    writer_state_e     state_q;
    logic [ADDR_W-1:0] addr_q, next_addr_q;
    logic [BIDX_W-1:0] beat_q;
    logic              last_seen_q;
    logic              burst_ready;

    assign burst_ready = (fifo_count >= CNT_W_F'(N_B));
    assign awaddr      = addr_q;
    assign awvalid     = (state_q == WR_ADDR);
    assign wvalid      = (state_q == WR_DATA);
    assign wdata       = head_data;
    assign wlast       = wvalid && (beat_q == BEAT_TOP);
    assign pop         = wvalid && wready;
    assign bready      = (state_q == WR_RESP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= WR_IDLE;
            addr_q      <= '0;
            next_addr_q <= '0;
            beat_q      <= '0;
            last_seen_q <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                WR_IDLE: begin
                    if (burst_ready) begin
                        if (head_tag.first) begin
                            addr_q <= head_tag.to_data ? data_base : other_base;
                        end else begin
                            addr_q <= next_addr_q;
                        end
                        beat_q      <= '0;
                        last_seen_q <= 1'b0;
                        state_q     <= WR_ADDR;
                    end
                end
                WR_ADDR: begin
                    if (awready) begin
                        state_q <= WR_DATA;
                    end
                end
                WR_DATA: begin
                    if (wready) begin
                        beat_q <= beat_q + 1'b1;
                        if (head_tag.last) begin
                            last_seen_q <= 1'b1;
                        end
                        if (beat_q == BEAT_TOP) begin
                            state_q <= WR_RESP;
                        end
                    end
                end
                WR_RESP: begin
                    if (bvalid) begin
                        next_addr_q <= addr_q + ADDR_W'(BURST_BYTES);
                        done        <= last_seen_q;
                        state_q     <= WR_IDLE;
                    end
                end
                default: state_q <= WR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fisrx_dma.sv
module fisrx_dma
    import fisrx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 2 * BURST_BEATS   // at least one burst
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WORD_W-1:0]    rx_data_i,
    input  logic                 rx_valid_i,
    input  logic                 rx_last_i,
    output logic                 rx_ready_o,
    input  logic [ADDR_W-1:0]    data_base_i,
    input  logic [ADDR_W-1:0]    other_base_i,
    output logic [ADDR_W-1:0]    m_awaddr,
    output logic [7:0]           m_awlen,
    output logic [2:0]           m_awsize,
    output logic [1:0]           m_awburst,
    output logic                 m_awvalid,
    input  logic                 m_awready,
    output logic [BEAT_W-1:0]    m_wdata,
    output logic [BEAT_W/8-1:0]  m_wstrb,
    output logic                 m_wlast,
    output logic                 m_wvalid,
    input  logic                 m_wready,
    input  logic                 m_bvalid,
    output logic                 m_bready,
    output logic [CNT_W-1:0]     pkt_words_o,
    output logic                 pkt_non_data_o,
    output logic                 pkt_done_o
);

    localparam int TAG_W   = $bits(beat_tag_t);
    localparam int ENTRY_W = BEAT_W + TAG_W;
    localparam int FCNT_W  = $clog2(FIFO_DEPTH) + 1;

    logic              push, fifo_full, pop;
    logic [BEAT_W-1:0] push_data;
    beat_tag_t         push_tag, head_tag;
    logic [ENTRY_W-1:0] head_entry;
    logic [FCNT_W-1:0] fifo_count;

    fisrx_ingest u_ingest (
        .clk        (clk),
        .rst        (rst),
        .rx_data    (rx_data_i),
        .rx_valid   (rx_valid_i),
        .rx_last    (rx_last_i),
        .rx_ready   (rx_ready_o),
        .fifo_full  (fifo_full),
        .push       (push),
        .push_data  (push_data),
        .push_tag   (push_tag),
        .word_count (pkt_words_o),
        .non_data   (pkt_non_data_o)
    );

    fisrx_beat_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data ({push_tag, push_data}),
        .pop       (pop),
        .head      (head_entry),
        .count     (fifo_count),
        .full      (fifo_full)
    );

    assign head_tag = beat_tag_t'(head_entry[ENTRY_W-1 -: TAG_W]);

    fisrx_axi_writer #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (BEAT_W),
        .CNT_W_F (FCNT_W)
    ) u_writer (
        .clk        (clk),
        .rst        (rst),
        .data_base  (data_base_i),
        .other_base (other_base_i),
        .fifo_count (fifo_count),
        .head_data  (head_entry[BEAT_W-1:0]),
        .head_tag   (head_tag),
        .pop        (pop),
        .awaddr     (m_awaddr),
        .awvalid    (m_awvalid),
        .awready    (m_awready),
        .wdata      (m_wdata),
        .wlast      (m_wlast),
        .wvalid     (m_wvalid),
        .wready     (m_wready),
        .bvalid     (m_bvalid),
        .bready     (m_bready),
        .done       (pkt_done_o)
    );

    assign m_awlen   = AXI_LEN;
    assign m_awsize  = AXI_SIZE;
    assign m_awburst = AXI_INCR;
    assign m_wstrb   = '1;

endmodule

// File: rtl/fisrx_dma_chk.sv
module fisrx_dma_chk
    import fisrx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   m_awaddr,
    input logic [7:0]          m_awlen,
    input logic [2:0]          m_awsize,
    input logic [1:0]          m_awburst,
    input logic                m_awvalid,
    input logic                m_awready,
    input logic [BEAT_W/8-1:0] m_wstrb,
    input logic                m_wlast,
    input logic                m_wvalid,
    input logic                m_wready,
    input logic                m_bvalid,
    input logic                m_bready,
    input logic                pkt_done_o
);

    localparam int BC_W = $clog2(BURST_BEATS) + 1;

    logic [BC_W-1:0] beats_seen;
    logic            aw_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_seen <= '0;
            aw_open    <= 1'b0;
        end else begin
            if (m_wvalid && m_wready) begin
                beats_seen <= m_wlast ? '0 : beats_seen + 1'b1;
            end
            if (m_awvalid && m_awready) begin
                aw_open <= 1'b1;
            end else if (m_wvalid && m_wready && m_wlast) begin
                aw_open <= 1'b0;
            end
        end
    end

    // R6
    burst_shape_chk: assert property (@(posedge clk) disable iff (rst)
        m_awvalid |-> (m_awlen == AXI_LEN) && (m_awsize == AXI_SIZE) && (m_awburst == AXI_INCR));

    // R6
    strobe_full_chk: assert property (@(posedge clk) disable iff (rst)
        m_wvalid |-> (&m_wstrb));

    // R6
    wlast_place_chk: assert property (@(posedge clk) disable iff (rst)
        (m_wvalid && m_wready) |-> (m_wlast == (beats_seen == BC_W'(BURST_BEATS - 1))));

    // R7
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    // R7
    w_gapless_chk: assert property (@(posedge clk) disable iff (rst)
        (m_wvalid && !(m_wready && m_wlast)) |=> m_wvalid);

    // R7
    w_after_aw_chk: assert property (@(posedge clk) disable iff (rst)
        m_wvalid |-> aw_open);

    // R9
    done_after_resp_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done_o |-> $past(m_bvalid && m_bready));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done_o |=> !pkt_done_o);

endmodule

bind fisrx_dma fisrx_dma_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fisrx_dma_tb_top.sv
module fisrx_dma_tb_top;

    localparam int   AW      = 32;
    localparam logic [31:0] DBASE = 32'h1000_0000;
    localparam logic [31:0] OBASE = 32'h0004_0000;
    localparam int   N_VEC   = 7;

    // stimulus: FIS code, word count, stall slave; expected: bursts
    localparam logic [7:0] VEC_CODE   [N_VEC] = '{8'h46, 8'h27, 8'h46, 8'h46, 8'h34, 8'h46, 8'h58};
    localparam int         VEC_LEN    [N_VEC] = '{9, 5, 129, 1, 128, 300, 130};
    localparam bit         VEC_HOLD   [N_VEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int         VEC_BURSTS [N_VEC] = '{1, 1, 1, 1, 1, 3, 2};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   rx_data = '0;
    logic          rx_valid = 1'b0;
    logic          rx_last = 1'b0;
    logic          rx_ready;
    logic [AW-1:0] m_awaddr;
    logic [7:0]    m_awlen;
    logic [2:0]    m_awsize;
    logic [1:0]    m_awburst;
    logic          m_awvalid;
    logic          m_awready = 1'b0;
    logic [255:0]  m_wdata;
    logic [31:0]   m_wstrb;
    logic          m_wlast;
    logic          m_wvalid;
    logic          m_wready = 1'b0;
    logic          m_bvalid = 1'b0;
    logic          m_bready;
    logic [23:0]   pkt_words;
    logic          pkt_non_data;
    logic          pkt_done;

    always #10 clk = ~clk;

    fisrx_dma #(.ADDR_W(AW)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .rx_data_i      (rx_data),
        .rx_valid_i     (rx_valid),
        .rx_last_i      (rx_last),
        .rx_ready_o     (rx_ready),
        .data_base_i    (DBASE),
        .other_base_i   (OBASE),
        .m_awaddr       (m_awaddr),
        .m_awlen        (m_awlen),
        .m_awsize       (m_awsize),
        .m_awburst      (m_awburst),
        .m_awvalid      (m_awvalid),
        .m_awready      (m_awready),
        .m_wdata        (m_wdata),
        .m_wstrb        (m_wstrb),
        .m_wlast        (m_wlast),
        .m_wvalid       (m_wvalid),
        .m_wready       (m_wready),
        .m_bvalid       (m_bvalid),
        .m_bready       (m_bready),
        .pkt_words_o    (pkt_words),
        .pkt_non_data_o (pkt_non_data),
        .pkt_done_o     (pkt_done)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit hold = 1'b0;

    // slave capture state
    logic [AW-1:0] cap_addr [0:63];
    logic [255:0]  cap_beat [0:1023];
    int cap_nb = 0, cap_nt = 0, fmt_err = 0, pend_b = 0, in_burst = 0;
    int done_cnt = 0, stall_cnt = 0, mcyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input int pkt, input logic [7:0] code, input int idx);
        if (idx == 0) return {8'hA5, 8'h46, 8'(pkt), code};
        return {8'(pkt), 8'h5C, 16'(idx)};
    endfunction

    function automatic logic [255:0] exp_beat(input int pkt, input logic [7:0] code,
                                              input int n, input int j);
        logic [255:0] b;
        bit is_d;
        int ns;
        is_d = (code == 8'h46);
        ns = is_d ? n - 1 : n;
        for (int l = 0; l < 8; l++) begin
            int k;
            k = 8 * j + l;
            b[l*32 +: 32] = (k < ns) ? mk_word(pkt, code, is_d ? k + 1 : k) : 32'h0;
        end
        return b;
    endfunction

    // AXI slave model: readies change at negedge, handshakes recorded 1 ns later
    initial begin
        forever begin
            @(negedge clk);
            mcyc++;
            m_awready = !hold && (mcyc % 3 != 0);
            m_wready  = !hold && (mcyc % 4 != 2);
            m_bvalid  = (pend_b > 0);
            #1;
            if (m_awvalid && m_awready) begin
                cap_addr[cap_nb % 64] = m_awaddr;
                cap_nb++;
                if (m_awlen != 8'd15 || m_awsize != 3'd5 || m_awburst != 2'b01) fmt_err++;
            end
            if (m_wvalid && m_wready) begin
                cap_beat[cap_nt % 1024] = m_wdata;
                cap_nt++;
                if (m_wstrb != '1) fmt_err++;
                if (m_wlast != (in_burst == 15)) fmt_err++;
                in_burst = m_wlast ? 0 : in_burst + 1;
                if (m_wlast) pend_b++;
            end
            if (m_bvalid && m_bready) pend_b--;
            if (pkt_done) done_cnt++;
            if (rx_valid && !rx_ready) stall_cnt++;
        end
    end

    task automatic send_packet(input int pkt, input logic [7:0] code, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = mk_word(pkt, code, i);
            rx_last  = (i == n - 1);
            #1;
            while (!rx_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int t;
        t = 0;
        while (done_cnt < target && t < 20000) begin
            @(negedge clk);
            t++;
        end
        #2;
    endtask

    // Compare captured bursts [b0, b0+nb) against one frame's expectation.
    task automatic check_bursts(input int pkt, input logic [7:0] code, input int n,
                                input int b0, input int t0, input int nb);
        bit a_ok, d_ok;
        logic [31:0] bad_a, bad_e;
        string req;
        logic [AW-1:0] base;
        req  = (code == 8'h46) ? "R2" : "R3";
        base = (code == 8'h46) ? DBASE : OBASE;
        a_ok = 1'b1;
        d_ok = 1'b1;
        bad_a = '0;
        bad_e = '0;
        for (int k = 0; k < nb; k++) begin
            if (cap_addr[(b0 + k) % 64] !== base + AW'(512 * k)) a_ok = 1'b0;
        end
        // R4 region base by class, 512-byte steps
        chk(a_ok, "R4", $sformatf("burst addresses frame %0d", pkt),
            longint'(cap_addr[b0 % 64]), longint'(base));
        for (int j = 0; j < nb * 16 && d_ok; j++) begin
            logic [255:0] e, a;
            e = exp_beat(pkt, code, n, j);
            a = cap_beat[(t0 + j) % 1024];
            if (a !== e) begin
                d_ok = 1'b0;
                for (int l = 0; l < 8; l++) begin
                    if (a[l*32 +: 32] !== e[l*32 +: 32] && bad_a == 0 && bad_e == 0) begin
                        bad_a = a[l*32 +: 32];
                        bad_e = e[l*32 +: 32];
                    end
                end
            end
        end
        // R2 / R3 packing, R5 zero padding
        chk(d_ok, req, $sformatf("beat data frame %0d", pkt), longint'(bad_a), longint'(bad_e));
    endtask

    initial begin
        int b0, t0, d0, f0, s0;
        repeat (4) @(negedge clk);
        // R11 reset values while reset is held
        chk(m_awvalid == 1'b0 && m_wvalid == 1'b0 && m_bready == 1'b0, "R11",
            "AXI valids in reset", longint'({m_awvalid, m_wvalid, m_bready}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_ready == 1'b1, "R11", "rx_ready after reset", longint'(rx_ready), 1);
        chk(pkt_done == 1'b0 && pkt_words == 24'd0 && pkt_non_data == 1'b0, "R11",
            "status after reset", longint'({pkt_done, pkt_non_data, pkt_words}), 0);

        for (int v = 0; v < N_VEC; v++) begin
            b0 = cap_nb;
            t0 = cap_nt;
            d0 = done_cnt;
            f0 = fmt_err;
            s0 = stall_cnt;
            fork
                send_packet(v, VEC_CODE[v], VEC_LEN[v]);
                begin
                    if (VEC_HOLD[v]) begin
                        hold = 1'b1;
                        repeat (400) @(negedge clk);
                        hold = 1'b0;
                    end
                end
            join
            // R8 status right after the last word
            chk(pkt_words == 24'(VEC_LEN[v]), "R8", $sformatf("word count frame %0d", v),
                longint'(pkt_words), longint'(VEC_LEN[v]));
            // R1 classification by low byte only
            chk(pkt_non_data == (VEC_CODE[v] != 8'h46), "R1", $sformatf("class frame %0d", v),
                longint'(pkt_non_data), longint'(VEC_CODE[v] != 8'h46));
            wait_done(d0 + 1);
            repeat (40) @(negedge clk);
            // R9 exactly one completion pulse
            chk(done_cnt == d0 + 1, "R9", $sformatf("done pulses frame %0d", v),
                longint'(done_cnt - d0), 1);
            // R5 burst count including padding
            chk(cap_nb - b0 == VEC_BURSTS[v], "R5", $sformatf("burst count frame %0d", v),
                longint'(cap_nb - b0), longint'(VEC_BURSTS[v]));
            // R6 burst shape, strobes, WLAST position
            chk(fmt_err == f0, "R6", $sformatf("burst format frame %0d", v),
                longint'(fmt_err - f0), 0);
            check_bursts(v, VEC_CODE[v], VEC_LEN[v], b0, t0, VEC_BURSTS[v]);
            if (VEC_HOLD[v]) begin
                // R10 back-pressure seen, data still intact (checked above)
                chk(stall_cnt > s0, "R10", "rx_ready dropped under stall",
                    longint'(stall_cnt - s0), 1);
            end
        end

        // Directed: two frames back to back, each restarts at its own base
        b0 = cap_nb;
        t0 = cap_nt;
        d0 = done_cnt;
        send_packet(20, 8'h46, 20);
        send_packet(21, 8'h39, 3);
        // R8 status follows the later frame
        chk(pkt_words == 24'd3 && pkt_non_data == 1'b1, "R8", "status after back-to-back",
            longint'({pkt_non_data, pkt_words}), longint'({1'b1, 24'd3}));
        wait_done(d0 + 2);
        repeat (40) @(negedge clk);
        chk(done_cnt == d0 + 2, "R9", "done pulses back-to-back", longint'(done_cnt - d0), 2);
        chk(cap_nb - b0 == 2, "R5", "bursts back-to-back", longint'(cap_nb - b0), 2);
        check_bursts(20, 8'h46, 20, b0, t0, 1);
        check_bursts(21, 8'h39, 3, b0 + 1, t0 + 16, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule